// File: doc/BRIEF.md
# Port Flit-Load Monitor with Acknowledged Reply

This block sits beside a five-port mesh router and measures how busy each input port is. Every input port has its own flit counter, which advances once for each flit that enters that port. A central routing controller asks for these figures by sending a network-state request. When a request arrives, the block freezes the five counts into a reply and clears the counters, so that each reply covers the interval since the previous accepted request.

The reply is protocol traffic, so the controller must acknowledge it. The block keeps the frozen reply and sends it again whenever a programmable timeout passes without an acknowledgement. If four retransmissions all go unanswered, the block gives up on the reply and raises a sticky error flag. Requests count only after a handshake message has been seen. A request that arrives while a reply is still waiting for its acknowledgement is ignored.

Message types on `msg_type` use these encodings: handshake 0x1, acknowledge 0x2, network-state request 0x6 and network-state reply 0x7. Ports are indexed 0 to 4 as North, East, South, West and Local.

Top module: `flit_load_monitor`

## Requirements
- R1: After reset, `reply_valid` and `err_flag` are low, no reply is pending, and all five counters read zero.
- R2: Each port's counter counts the cycles in which its `flit_in` bit is high. The reply packs port p in `reply_counts[16p+15:16p]`, with 0=North, 1=East, 2=South, 3=West and 4=Local.
- R3: A counter stops at 65535 and does not wrap.
- R4: A request (type 0x6) is accepted only after a handshake message (type 0x1) has been received. Before that, a request produces no reply and does not clear the counters.
- R5: In the cycle a request is accepted, the reply takes the counts as they were before that cycle, and the counters restart. A flit present in that same cycle counts as 1 toward the new interval.
- R6: `reply_valid` is high for exactly one cycle, in the cycle after the request is accepted, with `reply_type` equal to 0x7.
- R7: An acknowledge (type 0x2) received while a reply is pending ends the wait, and no further copies are sent. An acknowledge that arrives in the same cycle as the timeout expiry takes precedence over the resend.
- R8: While a reply is unacknowledged, `reply_valid` pulses again every `ack_timeout`+1 cycles, and `reply_counts` holds the same values throughout.
- R9: If four retransmissions go unacknowledged, the reply is dropped at the next expiry. At that point `err_flag` rises exactly 5×(`ack_timeout`+1) cycles after the first send, and it stays high until the next accepted request.
- R10: A request that arrives while a reply is pending causes no reply and does not clear the counters.
- R11: An acknowledge received while no reply is pending, and any message type other than 0x1, 0x2 or 0x6, has no effect on the counters or on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flit_in | input | 5 | One flit-entry strobe per input port (0=N, 1=E, 2=S, 3=W, 4=L) |
| msg_valid | input | 1 | A control message is present this cycle |
| msg_type | input | 4 | Type code of the control message |
| ack_timeout | input | 16 | Number of idle cycles to wait for an acknowledge before resending |
| reply_valid | output | 1 | One-cycle strobe: a reply is sent this cycle |
| reply_type | output | 4 | Type code of the reply (0x7) |
| reply_counts | output | 80 | Frozen per-port counts, 16 bits per port |
| err_flag | output | 1 | Sticky flag: a reply was dropped without acknowledgement |

## Verification
The two functions that can fall in the same cycle are the arrival of the acknowledge and the expiry of the retransmission timer. The bench sets a short timeout and places the acknowledge exactly in the cycle in which the timer reaches its limit. It judges the result by the absence of any further `reply_valid` pulse over many timeout periods. A second coincidence is also provoked: flits are driven in the same cycle as the accepted request. The bench then checks that those flits are missing from the reply just sent and appear in the next one.

// File: rtl/flm_pkg.sv
package flm_pkg;
  localparam logic [3:0] MSG_HELLO = 4'h1;
  localparam logic [3:0] MSG_ACK   = 4'h2;
  localparam logic [3:0] MSG_NSREQ = 4'h6;
  localparam logic [3:0] MSG_NSREP = 4'h7;

  typedef enum logic {
    RS_IDLE = 1'b0,
    RS_WAIT = 1'b1
  } rep_state_e;
endpackage

// File: rtl/flm_port_counter.sv
module flm_port_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc_i,
  input  logic          clr_i,
  output logic [CW-1:0] cnt_o
);
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = clr_i | inc_i;
    if (clr_i)                     cnt_d = inc_i ? CW'(1) : '0;
    else if (inc_i && cnt_q != CMAX) cnt_d = cnt_q + CW'(1);
    else                           cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R3: a full counter stays full without a clear
  a_r3_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && cnt_q == CMAX) |=> cnt_q == CMAX);
  // R2: one step per flit below the limit
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && inc_i && cnt_q != CMAX) |=> cnt_q == $past(cnt_q) + CW'(1));
  // R5: a clear restarts at the flit of the same cycle
  a_r5_restart: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> cnt_q <= CW'(1));
endmodule

// File: rtl/flm_reply_ctrl.sv
module flm_reply_ctrl
  import flm_pkg::*;
#(
  parameter int TW        = 16,
  parameter int MAX_RETRY = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_i,
  input  logic          ack_i,
  input  logic [TW-1:0] timeout_i,
  output logic          accept_o,
  output logic          send_o,
  output logic          pending_o,
  output logic          err_o
);
  localparam int RW = $clog2(MAX_RETRY + 1);

  rep_state_e    st_q, st_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic [RW-1:0] rty_q, rty_d;
  logic          send_q, send_d;
  logic          err_q, err_d;
  logic          expire;

  always_comb begin
    st_d     = st_q;
    tmr_d    = tmr_q;
    rty_d    = rty_q;
    send_d   = 1'b0;
    err_d    = err_q;
    accept_o = req_i && (st_q == RS_IDLE);
    expire   = (st_q == RS_WAIT) && !ack_i && (tmr_q >= timeout_i);
    case (st_q)
      RS_IDLE: begin
        if (accept_o) begin
          st_d   = RS_WAIT;
          tmr_d  = '0;
          rty_d  = '0;
          send_d = 1'b1;
          err_d  = 1'b0;
        end
      end
      RS_WAIT: begin
        if (ack_i) begin
          st_d = RS_IDLE;
        end else if (expire) begin
          if (rty_q == RW'(MAX_RETRY)) begin
            st_d  = RS_IDLE;
            err_d = 1'b1;
          end else begin
            send_d = 1'b1;
            rty_d  = rty_q + RW'(1);
            tmr_d  = '0;
          end
        end else begin
          tmr_d = tmr_q + TW'(1);
        end
      end
      default: st_d = RS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RS_IDLE;
      tmr_q  <= '0;
      rty_q  <= '0;
      send_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      tmr_q  <= tmr_d;
      rty_q  <= rty_d;
      send_q <= send_d;
      err_q  <= err_d;
    end
  end

  assign send_o    = send_q;
  assign pending_o = (st_q == RS_WAIT);
  assign err_o     = err_q;

  // R6: a send only ever happens while a reply is outstanding
  a_r6_send_pending: assert property (@(posedge clk) disable iff (!rst_n)
    send_q |-> st_q == RS_WAIT);
  // R7: an ACK while waiting closes the wait with no further copy
  a_r7_ack_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == RS_WAIT && ack_i) |=> (st_q == RS_IDLE && !send_q));
  // R9: retry count bounded
  a_r9_retry_bound: assert property (@(posedge clk) disable iff (!rst_n)
    rty_q <= RW'(MAX_RETRY));
  // R9: the error only appears when a pending reply is dropped
  a_r9_err_from_drop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> ($past(st_q) == RS_WAIT && st_q == RS_IDLE));
endmodule

// File: rtl/flit_load_monitor.sv
module flit_load_monitor
  import flm_pkg::*;
#(
  parameter int NPORTS    = 5,
  parameter int CW        = 16,
  parameter int TW        = 16,
  parameter int MAX_RETRY = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NPORTS-1:0]    flit_in,
  input  logic                 msg_valid,
  input  logic [3:0]           msg_type,
  input  logic [TW-1:0]        ack_timeout,
  output logic                 reply_valid,
  output logic [3:0]           reply_type,
  output logic [NPORTS*CW-1:0] reply_counts,
  output logic                 err_flag
);
  localparam int SW = NPORTS * CW;

  logic          hs_q, hs_d;
  logic          hello_seen, req_raw, ack_seen;
  logic          accept, pending;
  logic [SW-1:0] live_cnt;
  logic [SW-1:0] snap_q, snap_d;

  always_comb begin
    hello_seen = msg_valid && (msg_type == MSG_HELLO);
    ack_seen   = msg_valid && (msg_type == MSG_ACK);
    req_raw    = msg_valid && (msg_type == MSG_NSREQ) && hs_q;
    hs_d       = hs_q | hello_seen;
    snap_d     = accept ? live_cnt : snap_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q   <= 1'b0;
      snap_q <= '0;
    end else begin
      hs_q <= hs_d;
      if (accept) snap_q <= snap_d;
    end
  end

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    flm_port_counter #(.CW(CW)) cnt_i (
      .clk   (clk),
      .rst_n (rst_n),
      .inc_i (flit_in[p]),
      .clr_i (accept),
      .cnt_o (live_cnt[p*CW +: CW])
    );
  end

  flm_reply_ctrl #(.TW(TW), .MAX_RETRY(MAX_RETRY)) ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_i     (req_raw),
    .ack_i     (ack_seen),
    .timeout_i (ack_timeout),
    .accept_o  (accept),
    .send_o    (reply_valid),
    .pending_o (pending),
    .err_o     (err_flag)
  );

  assign reply_type   = MSG_NSREP;
  assign reply_counts = snap_q;

  // R8: the frozen counts hold while a reply is outstanding
  a_r8_hold_counts: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !accept) |=> $stable(reply_counts));
  // R4: nothing is accepted before the handshake
  a_r4_no_accept_early: assert property (@(posedge clk) disable iff (!rst_n)
    !hs_q |=> !reply_valid);
  // R10: a request during a pending reply does not restart the wait
  a_r10_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && req_raw) |-> !accept);
endmodule

// File: tb/flit_load_monitor_tb_top.sv
`timescale 1ns/1ps
module flit_load_monitor_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  flit_in;
  logic        msg_valid;
  logic [3:0]  msg_type;
  logic [15:0] ack_timeout;
  logic        reply_valid;
  logic [3:0]  reply_type;
  logic [79:0] reply_counts;
  logic        err_flag;

  int n_tests = 0;
  int n_fail  = 0;
  int mcnt[5];
  logic [79:0] exp_snap;

  always #2.5 clk = ~clk;

  flit_load_monitor dut_i (
    .clk(clk), .rst_n(rst_n), .flit_in(flit_in), .msg_valid(msg_valid),
    .msg_type(msg_type), .ack_timeout(ack_timeout), .reply_valid(reply_valid),
    .reply_type(reply_type), .reply_counts(reply_counts), .err_flag(err_flag)
  );

  function automatic logic [79:0] pack_model();
    logic [79:0] r;
    for (int p = 0; p < 5; p++) r[p*16 +: 16] = 16'(mcnt[p]);
    return r;
  endfunction

  task automatic check(input string req, input logic [79:0] act, input logic [79:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input logic [4:0] f, input logic v, input logic [3:0] t, input bit acc);
    @(negedge clk);
    flit_in = f; msg_valid = v; msg_type = t;
    @(posedge clk);
    if (acc) begin
      exp_snap = pack_model();
      for (int p = 0; p < 5; p++) mcnt[p] = int'(f[p]);
    end else begin
      for (int p = 0; p < 5; p++) if (f[p] && mcnt[p] < 65535) mcnt[p]++;
    end
    #1;
  endtask

  task automatic idle_quiet(input int n, input string req);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      tick(5'b0, 1'b0, 4'h0, 1'b0);
      if (reply_valid) seen++;
    end
    check(req, 80'(seen), 80'd0);
  endtask

  initial begin
    #(150000 * 5);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int p = 0; p < 5; p++) mcnt[p] = 0;
    exp_snap = '0;
    rst_n = 1'b0; flit_in = '0; msg_valid = 1'b0; msg_type = '0; ack_timeout = 16'd10;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reply_valid", 80'(reply_valid), 80'd0);
    check("R1 err_flag", 80'(err_flag), 80'd0);
    @(negedge clk); rst_n = 1'b1;

    // R4: request before handshake ignored, counters keep their flit
    tick(5'b00001, 1'b1, 4'h6, 1'b0);
    idle_quiet(4, "R4 no reply before handshake");
    tick(5'b00000, 1'b1, 4'h1, 1'b0);

    // R2/R5/R6: varied flit patterns, request with flits in same cycle
    for (int i = 0; i < 40; i++) tick(5'((i * 7 + 3) ^ (i >> 1)), 1'b0, 4'h0, 1'b0);
    tick(5'b10101, 1'b1, 4'h6, 1'b1);
    check("R6 reply_valid pulse", 80'(reply_valid), 80'd1);
    check("R6 reply_type", 80'(reply_type), 80'h7);
    check("R2 counts after pattern", reply_counts, exp_snap);
    tick(5'b0, 1'b0, 4'h0, 1'b0);
    check("R6 single-cycle pulse", 80'(reply_valid), 80'd0);
    tick(5'b0, 1'b1, 4'h2, 1'b0);
    idle_quiet(40, "R7 no resend after ACK");

    // R5: flits from the snapshot cycle appear in the next reply
    for (int i = 0; i < 9; i++) tick(5'(1 << (i % 5)), 1'b0, 4'h0, 1'b0);
    tick(5'b0, 1'b1, 4'h6, 1'b1);
    check("R5 snapshot-cycle flits in next interval", reply_counts, exp_snap);
    tick(5'b0, 1'b1, 4'h2, 1'b0);

    // R11: stray ACK and other types have no effect
    tick(5'b00110, 1'b1, 4'h2, 1'b0);
    tick(5'b01000, 1'b1, 4'h5, 1'b0);
    tick(5'b10000, 1'b1, 4'h8, 1'b0);
    idle_quiet(3, "R11 no reply from other types");
    tick(5'b0, 1'b1, 4'h6, 1'b1);
    check("R11 counts unaffected by other types", reply_counts, exp_snap);
    tick(5'b0, 1'b1, 4'h2, 1'b0);

    // R10: request while pending is ignored and does not clear
    ack_timeout = 16'd30;
    tick(5'b00011, 1'b1, 4'h6, 1'b1);
    tick(5'b11111, 1'b1, 4'h6, 1'b0);
    check("R10 no reply for busy request", 80'(reply_valid), 80'd0);
    idle_quiet(3, "R10 no extra pulse");
    tick(5'b0, 1'b1, 4'h2, 1'b0);
    tick(5'b0, 1'b1, 4'h6, 1'b1);
    check("R10 counts kept through busy request", reply_counts, exp_snap);
    tick(5'b0, 1'b1, 4'h2, 1'b0);

    // R7: ACK in the very cycle the timer expires (timeout 2)
    ack_timeout = 16'd2;
    tick(5'b0, 1'b1, 4'h6, 1'b1);
    tick(5'b0, 1'b0, 4'h0, 1'b0);
    tick(5'b0, 1'b0, 4'h0, 1'b0);
    tick(5'b0, 1'b1, 4'h2, 1'b0);
    check("R7 ACK beats expiry", 80'(reply_valid), 80'd0);
    idle_quiet(20, "R7 quiet after coincident ACK");

    // R8/R9: sweep timeouts, count copies and error timing
    for (int t = 0; t < 5; t++) begin
      int pulses, errat, badgap, badval;
      ack_timeout = 16'(t);
      tick(5'b0, 1'b1, 4'h6, 1'b1);
      pulses = int'(reply_valid); errat = -1; badgap = 0; badval = 0;
      for (int c = 1; c <= 5 * (t + 1) + 3; c++) begin
        tick(5'b0, 1'b0, 4'h0, 1'b0);
        if (reply_valid) begin
          pulses++;
          if (c % (t + 1) != 0) badgap++;
        end
        if (reply_counts !== exp_snap) badval++;
        if (err_flag && errat < 0) errat = c;
      end
      check("R8 resend spacing", 80'(badgap), 80'd0);
      check("R8 counts held", 80'(badval), 80'd0);
      check("R9 five copies", 80'(pulses), 80'd5);
      check("R9 drop cycle", 80'(errat), 80'(5 * (t + 1)));
      tick(5'b0, 1'b1, 4'h6, 1'b1);
      check("R9 err cleared by new request", 80'(err_flag), 80'd0);
      tick(5'b0, 1'b1, 4'h2, 1'b0);
    end

    // R3: saturation on the West port
    ack_timeout = 16'd10;
    for (int i = 0; i < 65600; i++) tick(5'b01000 | 5'(i & 1), 1'b0, 4'h0, 1'b0);
    tick(5'b0, 1'b1, 4'h6, 1'b1);
    check("R3 west saturates", 80'(reply_counts[63:48]), 80'd65535);
    check("R3 full reply", reply_counts, exp_snap);
    tick(5'b0, 1'b1, 4'h2, 1'b0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule